// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block routes interrupt requests from a set of input lines to a single outgoing delivery channel. Each of its 24 pins owns a 64-bit redirection entry. The entry selects the vector, the delivery mode, the destination mode, the trigger mode, the destination and a mask. A per-pin pending bit records requests. A per-pin remote-IRR bit locks out a level-triggered pin after it is delivered. A small state machine scans the unmasked pending pins and commits them one at a time into a registered delivery message on a valid/ready port. When a message carries the external-interrupt delivery mode, its vector comes from an external vector supplier, which the block signals through a request output.

Software reaches the block through three inputs. An entry-write port loads a whole 64-bit entry. An end-of-interrupt port carries a vector, and it releases every locked level pin whose entry holds that vector. The input-event port carries a line number and a level. Line 0 is steered onto pin 2.

The state machine has two states. ST_IDLE means no message is held. ST_SEND means a message is on the port. There are four transitions. *Offer* goes from ST_IDLE to ST_SEND when any pin is eligible. *Stall* holds ST_SEND while the port is not ready. *Chain* stays in ST_SEND when a message is accepted and another pin is eligible. *Drain* goes from ST_SEND back to ST_IDLE when a message is accepted and no pin is eligible. Each offer or chain commits the chosen pin in that same cycle. For an edge pin the commit clears its pending bit. For a level pin it sets remote-IRR.

Top module: `intr_router`

## Requirements
- R1: After reset every entry has its mask bit (bit 16) set, all pending and remote-IRR bits are clear, and dlv_valid and ext_vec_req are low. An input event on a pin that still holds its reset entry produces no delivery.
- R2: An edge pin has bit 15 = 0. On an unmasked edge pin, an event with level 1 causes exactly one delivery. The delivered fields are taken from the entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, trigger mode from bit 15 and destination from bits 63:56. An event with level 0 does nothing.
- R3: An edge event on a masked pin is discarded. Unmasking the pin afterwards produces no delivery.
- R4: A level pin has bit 15 = 1. On a level pin, level 1 sets the pending bit and level 0 clears it, whether or not the pin is masked. A masked pin is never delivered while it is masked.
- R5: Delivering a level pin sets its remote-IRR bit and leaves the pending bit set. No further delivery of that pin occurs while remote-IRR is set, even if the input is asserted again.
- R6: An end-of-interrupt with vector V clears remote-IRR on every entry that has remote-IRR set and vector V. Such a pin is delivered again if it is still pending and unmasked. A non-matching vector has no effect.
- R7: Input line 0 drives pin 2. Lines 1 to 23 drive the pin of the same number. Lines of 24 and above are ignored.
- R8: When several pins are eligible, they are committed in ascending pin order. With dlv_ready high, one message is accepted in each consecutive cycle.
- R9: While dlv_valid is high and dlv_ready is low, the message is held unchanged.
- R10: When the delivery mode is 3'b111 (external), dlv_vector follows the ext_vec input and ext_vec_req is high while that message is offered. In every other mode, dlv_vector is entry bits 7:0.
- R11: A write to an entry takes effect for the scan on the next cycle, so unmasking a pending pin leads to its delivery. Bit 14 of the written data is ignored: remote-IRR is kept by hardware.
- R12: An edge event on a pin in the same cycle that the pin is committed is kept, and it produces a second delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Input event strobe |
| req_line | input | 8 | Input line number of the event |
| req_level | input | 1 | Level carried by the event |
| ent_wr | input | 1 | Entry write strobe |
| ent_idx | input | 5 | Pin whose entry is written |
| ent_wdata | input | 64 | New entry contents |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| ext_vec | input | 8 | Vector from the external supplier |
| dlv_ready | input | 1 | Downstream accepts the message |
| dlv_valid | output | 1 | Message offered |
| dlv_dest | output | 8 | Destination field |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Delivered vector |
| dlv_trig | output | 1 | Trigger mode, 1 = level |
| ext_vec_req | output | 1 | Request to the external vector supplier |

## Verification
Two functions can fall in one cycle: the commit of an edge pin, which clears its pending bit, and a new event on that same pin, which sets it. The bench provokes this by driving two back-to-back events on one edge pin with the port ready. The first event is committed in the same cycle the second arrives. Exactly two deliveries must follow; losing the second event would leave only one. A second case overlaps a stalled message with new requests arriving. It is judged by the held message staying constant and by the accepted order afterwards.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
    localparam int ENTRY_W  = 64;
    localparam int VEC_W    = 8;
    localparam int VEC_LSB  = 0;
    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 8;
    localparam int DSTM_BIT = 11;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    localparam int DEST_W   = 8;
    localparam int DEST_LSB = 56;

    localparam logic [MODE_W-1:0] MODE_EXTERNAL = 3'b111;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fsm_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_mode;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
        logic              trig;
    } msg_t;
endpackage

// File: rtl/intr_pin_slot.sv
module intr_pin_slot
    import intr_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               req_hit,
    input  logic               req_level,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vec,
    input  logic               commit,
    output msg_t               msg,
    output logic               eligible
);
    logic [VEC_W-1:0]  vec_q;
    logic [MODE_W-1:0] mode_q;
    logic [DEST_W-1:0] dest_q;
    logic              dstm_q, trig_q, mask_q, pend_q, rirr_q;
    logic              pend_d, rirr_d, eoi_match;

    assign eoi_match = eoi_valid && rirr_q && (vec_q == eoi_vec);

    always_comb begin
        pend_d = pend_q;
        if (trig_q) begin
            if (req_hit) pend_d = req_level;
        end else begin
            if (commit) pend_d = 1'b0;
            if (req_hit && req_level && !mask_q) pend_d = 1'b1;
        end
        rirr_d = (rirr_q && !eoi_match) || (commit && trig_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mode_q <= '0;
            dest_q <= '0;
            dstm_q <= 1'b0;
            trig_q <= 1'b0;
            mask_q <= 1'b1;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            rirr_q <= rirr_d;
            if (wr_en) begin
                vec_q  <= wr_data[VEC_LSB +: VEC_W];
                mode_q <= wr_data[MODE_LSB +: MODE_W];
                dest_q <= wr_data[DEST_LSB +: DEST_W];
                dstm_q <= wr_data[DSTM_BIT];
                trig_q <= wr_data[TRIG_BIT];
                mask_q <= wr_data[MASK_BIT];
            end
        end
    end

    assign eligible = pend_q && !mask_q && (!trig_q || !rirr_q);
    assign msg = '{dest: dest_q, dest_mode: dstm_q, mode: mode_q,
                   vector: vec_q, trig: trig_q};
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
    parameter  int N = 24,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_router_pkg::*;
#(
    parameter  int NUM_PINS = 24,
    parameter  int LINE_W   = 8,
    localparam int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LINE_W-1:0]  req_line,
    input  logic               req_level,
    input  logic               ent_wr,
    input  logic [PIN_W-1:0]   ent_idx,
    input  logic [ENTRY_W-1:0] ent_wdata,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    input  logic [VEC_W-1:0]   ext_vec,
    input  logic               dlv_ready,
    output logic               dlv_valid,
    output logic [DEST_W-1:0]  dlv_dest,
    output logic               dlv_dest_mode,
    output logic [MODE_W-1:0]  dlv_mode,
    output logic [VEC_W-1:0]   dlv_vector,
    output logic               dlv_trig,
    output logic               ext_vec_req
);
    localparam logic [LINE_W-1:0] REROUTE_PIN = LINE_W'(2);

    fsm_e                state_q, state_d;
    msg_t                msg_q;
    msg_t                msg_arr [NUM_PINS];
    logic [NUM_PINS-1:0] eligible_vec, commit_vec;
    logic [LINE_W-1:0]   line_eff;
    logic                line_ok, found, commit_en;
    logic [PIN_W-1:0]    pick_idx;

    assign line_eff = (req_line == '0) ? REROUTE_PIN : req_line;
    assign line_ok  = req_valid && (line_eff < LINE_W'(NUM_PINS));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        intr_pin_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ent_wr && (ent_idx == PIN_W'(g))),
            .wr_data   (ent_wdata),
            .req_hit   (line_ok && (line_eff == LINE_W'(g))),
            .req_level (req_level),
            .eoi_valid (eoi_valid),
            .eoi_vec   (eoi_vector),
            .commit    (commit_vec[g]),
            .msg       (msg_arr[g]),
            .eligible  (eligible_vec[g])
        );
    end

    intr_pick #(.N(NUM_PINS)) u_pick (
        .req   (eligible_vec),
        .found (found),
        .idx   (pick_idx)
    );

    assign commit_en  = found && ((state_q == ST_IDLE) || dlv_ready);
    assign commit_vec = commit_en ? (NUM_PINS'(1) << pick_idx) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (found) state_d = ST_SEND;
            ST_SEND: if (dlv_ready) state_d = found ? ST_SEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         msg_q <= '0;
        else if (commit_en) msg_q <= msg_arr[pick_idx];
    end

    assign dlv_valid     = (state_q == ST_SEND);
    assign dlv_dest      = msg_q.dest;
    assign dlv_dest_mode = msg_q.dest_mode;
    assign dlv_mode      = msg_q.mode;
    assign dlv_trig      = msg_q.trig;
    assign dlv_vector    = (msg_q.mode == MODE_EXTERNAL) ? ext_vec : msg_q.vector;
    assign ext_vec_req   = dlv_valid && (msg_q.mode == MODE_EXTERNAL);
endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [7:0]          dlv_dest,
    input logic                dlv_dest_mode,
    input logic [2:0]          dlv_mode,
    input logic [7:0]          dlv_vector,
    input logic                dlv_trig,
    input logic                ext_vec_req,
    input logic [NUM_PINS-1:0] commit_vec,
    input logic [NUM_PINS-1:0] eligible_vec
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_dest) &&
        $stable(dlv_dest_mode) && $stable(dlv_mode) && $stable(dlv_trig));

    // R9
    stall_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready && dlv_mode != 3'b111 |=> $stable(dlv_vector));

    // R8
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_vec));

    // R8
    commit_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_vec) |=> dlv_valid);

    // R5
    commit_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vec & ~eligible_vec) == '0);

    // R10
    ext_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vec_req |-> dlv_valid && dlv_mode == 3'b111);
endmodule

bind intr_router intr_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dlv_valid     (dlv_valid),
    .dlv_ready     (dlv_ready),
    .dlv_dest      (dlv_dest),
    .dlv_dest_mode (dlv_dest_mode),
    .dlv_mode      (dlv_mode),
    .dlv_vector    (dlv_vector),
    .dlv_trig      (dlv_trig),
    .ext_vec_req   (ext_vec_req),
    .commit_vec    (commit_vec),
    .eligible_vec  (eligible_vec)
);

// File: tb/intr_router_test.sv
module intr_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_line = '0;
    logic        req_level = 1'b0;
    logic        ent_wr = 1'b0;
    logic [4:0]  ent_idx = '0;
    logic [63:0] ent_wdata = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic [7:0]  ext_vec = '0;
    logic        dlv_ready = 1'b1;
    logic        dlv_valid, dlv_dest_mode, dlv_trig, ext_vec_req;
    logic [7:0]  dlv_dest, dlv_vector;
    logic [2:0]  dlv_mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_log = 0;
    logic [7:0] lg_vec [64];
    logic [7:0] lg_dest [64];
    logic [2:0] lg_mode [64];
    logic       lg_dm [64];
    logic       lg_trig [64];
    int         lg_cyc [64];

    always #5 clk = ~clk;

    intr_router uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_level(req_level), .ent_wr(ent_wr), .ent_idx(ent_idx),
        .ent_wdata(ent_wdata), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .ext_vec(ext_vec), .dlv_ready(dlv_ready), .dlv_valid(dlv_valid),
        .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
        .dlv_vector(dlv_vector), .dlv_trig(dlv_trig), .ext_vec_req(ext_vec_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && dlv_valid && dlv_ready) begin
            if (n_log < 64) begin
                lg_vec[n_log]  <= dlv_vector;
                lg_dest[n_log] <= dlv_dest;
                lg_mode[n_log] <= dlv_mode;
                lg_dm[n_log]   <= dlv_dest_mode;
                lg_trig[n_log] <= dlv_trig;
                lg_cyc[n_log]  <= cyc;
            end
            n_log <= n_log + 1;
        end
        if (cyc > 50000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] mk(logic [7:0] vec, logic [2:0] mode, logic dm,
                                       logic trig, logic mask, logic [7:0] dest);
        logic [63:0] e = '0;
        e[7:0] = vec; e[10:8] = mode; e[11] = dm;
        e[15] = trig; e[16] = mask; e[63:56] = dest;
        return e;
    endfunction

    task automatic wr_entry(int idx, logic [63:0] d);
        @(negedge clk);
        ent_wr = 1'b1; ent_idx = 5'(idx); ent_wdata = d;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    task automatic line_ev(int line, logic lvl);
        @(negedge clk);
        req_valid = 1'b1; req_line = 8'(line); req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic eoi_ev(int v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = 8'(v);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        int base;
        check_eq("R1", "dlv_valid after reset", int'(dlv_valid), 0);
        check_eq("R1", "ext_vec_req after reset", int'(ext_vec_req), 0);
        base = n_log;
        line_ev(5, 1'b1);
        line_ev(5, 1'b0);
        tick(5);
        check_eq("R1", "deliveries on reset entry", n_log - base, 0);
    endtask

    task automatic t_edge();
        int base = n_log;
        wr_entry(3, mk(8'h33, 3'b001, 1'b1, 1'b0, 1'b0, 8'hA5));
        line_ev(3, 1'b1);
        tick(5);
        check_eq("R2", "edge delivery count", n_log - base, 1);
        check_eq("R2", "vector", int'(lg_vec[base]), 'h33);
        check_eq("R2", "dest", int'(lg_dest[base]), 'hA5);
        check_eq("R2", "mode", int'(lg_mode[base]), 1);
        check_eq("R2", "dest mode", int'(lg_dm[base]), 1);
        check_eq("R2", "trig", int'(lg_trig[base]), 0);
        line_ev(3, 1'b0);
        tick(5);
        check_eq("R2", "level 0 on edge pin", n_log - base, 1);
    endtask

    task automatic t_masked_edge();
        int base = n_log;
        wr_entry(4, mk(8'h44, 3'b000, 1'b0, 1'b0, 1'b1, 8'h01));
        line_ev(4, 1'b1);
        tick(3);
        wr_entry(4, mk(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 8'h01));
        tick(5);
        check_eq("R3", "masked edge dropped", n_log - base, 0);
    endtask

    task automatic t_level_mask();
        int base = n_log;
        wr_entry(6, mk(8'h66, 3'b000, 1'b0, 1'b1, 1'b1, 8'h02));
        line_ev(6, 1'b1);
        tick(5);
        check_eq("R4", "masked level not delivered", n_log - base, 0);
        wr_entry(6, mk(8'h66, 3'b000, 1'b0, 1'b1, 1'b0, 8'h02));
        tick(5);
        check_eq("R11", "unmask write rescans", n_log - base, 1);
        line_ev(6, 1'b0);
        eoi_ev('h66);
        tick(5);
        check_eq("R4", "deasserted level not redelivered", n_log - base, 1);
        wr_entry(7, mk(8'h77, 3'b000, 1'b0, 1'b1, 1'b1, 8'h02));
        line_ev(7, 1'b1);
        line_ev(7, 1'b0);
        wr_entry(7, mk(8'h77, 3'b000, 1'b0, 1'b1, 1'b0, 8'h02));
        tick(5);
        check_eq("R4", "level cleared while masked", n_log - base, 1);
    endtask

    task automatic t_level_eoi();
        int base = n_log;
        wr_entry(8, mk(8'h88, 3'b000, 1'b0, 1'b1, 1'b0, 8'h11));
        line_ev(8, 1'b1);
        tick(5);
        check_eq("R5", "first level delivery", n_log - base, 1);
        check_eq("R5", "trig bit level", int'(lg_trig[base]), 1);
        line_ev(8, 1'b1);
        tick(5);
        check_eq("R5", "locked by remote-IRR", n_log - base, 1);
        eoi_ev('h89);
        tick(5);
        check_eq("R6", "non-matching EOI", n_log - base, 1);
        eoi_ev('h88);
        tick(5);
        check_eq("R6", "matching EOI redelivers", n_log - base, 2);
        line_ev(8, 1'b0);
        eoi_ev('h88);
        tick(5);
        check_eq("R6", "EOI after deassert", n_log - base, 2);
    endtask

    task automatic t_lines();
        int base = n_log;
        wr_entry(2, mk(8'h22, 3'b000, 1'b0, 1'b0, 1'b0, 8'h03));
        wr_entry(0, mk(8'h20, 3'b000, 1'b0, 1'b0, 1'b0, 8'h03));
        line_ev(0, 1'b1);
        tick(5);
        check_eq("R7", "line 0 count", n_log - base, 1);
        check_eq("R7", "line 0 goes to pin 2", int'(lg_vec[base]), 'h22);
        line_ev(24, 1'b1);
        line_ev(200, 1'b1);
        tick(5);
        check_eq("R7", "out-of-range lines ignored", n_log - base, 1);
    endtask

    task automatic t_order_stall();
        int base;
        dlv_ready = 1'b0;
        wr_entry(12, mk(8'hC0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h04));
        wr_entry(11, mk(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h04));
        wr_entry(10, mk(8'hA0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h04));
        wr_entry(9,  mk(8'h90, 3'b000, 1'b0, 1'b0, 1'b0, 8'h04));
        line_ev(12, 1'b1);
        tick(2);
        line_ev(11, 1'b1);
        line_ev(10, 1'b1);
        line_ev(9, 1'b1);
        tick(3);
        check_eq("R9", "valid during stall", int'(dlv_valid), 1);
        check_eq("R9", "held vector", int'(dlv_vector), 'hC0);
        tick(2);
        check_eq("R9", "held vector later", int'(dlv_vector), 'hC0);
        base = n_log;
        dlv_ready = 1'b1;
        tick(6);
        check_eq("R8", "burst count", n_log - base, 4);
        check_eq("R8", "order 0", int'(lg_vec[base]), 'hC0);
        check_eq("R8", "order 1", int'(lg_vec[base + 1]), 'h90);
        check_eq("R8", "order 2", int'(lg_vec[base + 2]), 'hA0);
        check_eq("R8", "order 3", int'(lg_vec[base + 3]), 'hB0);
        for (int i = 0; i < 3; i++)
            check_eq("R8", "consecutive cycles", lg_cyc[base + i + 1] - lg_cyc[base + i], 1);
    endtask

    task automatic t_external();
        int base;
        dlv_ready = 1'b0;
        ext_vec = 8'h5A;
        wr_entry(13, mk(8'h13, 3'b111, 1'b0, 1'b0, 1'b0, 8'h05));
        line_ev(13, 1'b1);
        tick(2);
        check_eq("R10", "ext request", int'(ext_vec_req), 1);
        check_eq("R10", "ext vector", int'(dlv_vector), 'h5A);
        check_eq("R10", "ext mode", int'(dlv_mode), 7);
        ext_vec = 8'h6B;
        #1;
        check_eq("R10", "ext vector follows supplier", int'(dlv_vector), 'h6B);
        base = n_log;
        dlv_ready = 1'b1;
        tick(3);
        check_eq("R10", "ext delivered vector", int'(lg_vec[base]), 'h6B);
        check_eq("R10", "ext request drops", int'(ext_vec_req), 0);
    endtask

    task automatic t_rirr_write();
        int base = n_log;
        logic [63:0] e = mk(8'hE4, 3'b000, 1'b0, 1'b1, 1'b0, 8'h06);
        e[14] = 1'b1;
        wr_entry(14, e);
        line_ev(14, 1'b1);
        tick(5);
        check_eq("R11", "written bit 14 ignored", n_log - base, 1);
        line_ev(14, 1'b0);
        eoi_ev('hE4);
    endtask

    task automatic t_same_cycle();
        int base = n_log;
        wr_entry(15, mk(8'hF5, 3'b000, 1'b0, 1'b0, 1'b0, 8'h07));
        @(negedge clk);
        req_valid = 1'b1; req_line = 8'd15; req_level = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        tick(6);
        check_eq("R12", "event during commit kept", n_log - base, 2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_edge();
        t_masked_edge();
        t_level_mask();
        t_level_eoi();
        t_lines();
        t_order_stall();
        t_external();
        t_rirr_write();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule